// File: doc/BRIEF.md
# Two-Group Interrupt Priority Selector

This block serves one processor interface of an interrupt controller. Every cycle it looks at all interrupt sources and finds the one that is both enabled and pending with the most urgent priority. A numerically smaller priority value is more urgent. Each source belongs to one of two security groups: group 0 (secure) or group 1 (non-secure). The block decides whether the winner is reported as the pending ID. It also decides whether the winner raises the normal interrupt line, the fast interrupt line, or neither.

The decision takes into account the distributor-wide enable for each group, the interface enables for each group, and the interface fast-interrupt steering bit. It also compares the winner's priority against the interface priority mask and against the priority of the interrupt currently running. The choice is combinational across all sources. The three outputs are registered, so they follow the inputs one clock later. A system with several processor interfaces uses one instance per interface.

Top module: `grp_prio_select`

## Requirements
- R1: While reset is held, and in the first cycle after it, `irq_o` and `fiq_o` are 0 and `pend_id_o` is 1023.
- R2: Only sources whose enable and pending bits are both 1 compete. Among them, the one with the smallest 8-bit priority value wins, at any source index from 0 to N_SRC-1. A priority of 0xFF is still a valid candidate.
- R3: When candidates have equal priority, the source with the lowest index wins.
- R4: If both distributor group enables are 0, or both interface group enables are 0, then `irq_o` and `fiq_o` are 0 and `pend_id_o` is 1023.
- R5: The winner's index appears on `pend_id_o` only when its priority is strictly below `prio_mask_i`. Otherwise `pend_id_o` is 1023 and no line is raised. A mask of 0x100 passes every priority.
- R6: A line is raised only when the winner's priority is strictly below `run_prio_i`. If the winner passes the mask but not the running priority, its ID is still reported. A value of 0x100 means nothing is running.
- R7: A line is raised only when the winner's group is enabled at the distributor. A more urgent winner whose group is disabled there is still reported, and it hides any less urgent source in the other group.
- R8: `src_grp_i` bit = 0 marks a source as group 0 and 1 marks group 1. A signalled group-0 winner raises `fiq_o`, and not `irq_o`, when `if_fiq_en_i` and `if_en_g0_i` are both 1.
- R9: A signalled group-0 winner with `if_fiq_en_i` = 1 and `if_en_g0_i` = 0 raises neither line.
- R10: A signalled winner that is not steered to FIQ raises `irq_o` when its own group's interface enable is 1 (`if_en_g0_i` for group 0, `if_en_g1_i` for group 1). Otherwise it raises nothing. `if_fiq_en_i` has no effect on group-1 winners.
- R11: Outputs change on the first rising clock edge after the inputs change. Between edges they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en_i | input | N_SRC | Per-source enable |
| src_pend_i | input | N_SRC | Per-source pending |
| src_grp_i | input | N_SRC | Per-source group (0 = group 0, 1 = group 1) |
| src_prio_i | input | 8*N_SRC | Per-source priority; source k uses bits [8k+7:8k] |
| dist_en_g0_i | input | 1 | Distributor enable for group 0 |
| dist_en_g1_i | input | 1 | Distributor enable for group 1 |
| if_en_g0_i | input | 1 | Interface enable for group 0 |
| if_en_g1_i | input | 1 | Interface enable for group 1 |
| if_fiq_en_i | input | 1 | Steer signalled group-0 winners to the fast line |
| prio_mask_i | input | 9 | Priority mask (0x100 passes all priorities) |
| run_prio_i | input | 9 | Running priority (0x100 = idle) |
| pend_id_o | output | 10 | Reported winner ID, 1023 when none |
| irq_o | output | 1 | Normal interrupt level |
| fiq_o | output | 1 | Fast interrupt level |

## Verification
The hardest case to reach from the ports is a winner that is reported but does not signal. One example is a group-1 winner whose distributor group enable is off while the interface stays active, with a less urgent group-0 source that would otherwise fire. Another is a group-0 winner that is steered to FIQ while its interface enable is off. The stimulus builds each of these directly: it places a more urgent source in the disabled group next to a less urgent one in the enabled group. It then switches the enables one at a time, so that the design is never in the fully disabled state of R4. Ties at priority 0xFF between indices 0 and 63, and masks exactly equal to the winner's priority, cover the strict comparisons.

// File: rtl/grp_prio_pkg.sv
// Package grp_prio_pkg
// Shared widths, the reserved "no interrupt" ID and the candidate record
// that moves through the comparison tree.
package grp_prio_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    // One extra bit so that 0x100 means "no candidate" or "idle".
    localparam int PCMP_W = PRIO_W + 1;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    typedef struct packed {
        logic [PCMP_W-1:0] prio;
        logic [ID_W-1:0]   id;
        logic              grp;   // 1 = group 1, 0 = group 0
    } cand_t;

    localparam cand_t CAND_NONE = '{prio: 9'h100, id: ID_NONE, grp: 1'b0};
endpackage

// File: rtl/grp_prio_tree.sv
// Module grp_prio_tree
// Purpose: finds the most urgent eligible source, meaning the one with the
//          smallest priority value, using a balanced tree of pairwise
//          comparisons.
// Assumes: 2 <= N_SRC <= 1022. Leaves are padded to a power of two with
//          empty candidates. The left (lower-index) operand wins on ties.
module grp_prio_tree
    import grp_prio_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic [N_SRC-1:0]        elig_i,
    input  logic [N_SRC-1:0]        grp_i,
    input  logic [PRIO_W*N_SRC-1:0] prio_i,
    output cand_t                   best_o
);
    localparam int LOG    = $clog2(N_SRC);
    localparam int LEAVES = 1 << LOG;

    for (genvar l = 0; l <= LOG; l++) begin : g_lvl
        localparam int W = LEAVES >> l;
        cand_t v [W];
        if (l == 0) begin : g_leaf
            // Leaf stage: turn each source into a candidate, or an empty one.
            for (genvar i = 0; i < W; i++) begin : g_i
                if (i < N_SRC) begin : g_real
                    assign v[i] = elig_i[i]
                        ? '{prio: {1'b0, prio_i[i*PRIO_W +: PRIO_W]},
                            id: ID_W'(i), grp: grp_i[i]}
                        : CAND_NONE;
                end else begin : g_pad
                    assign v[i] = CAND_NONE;
                end
            end
        end else begin : g_node
            // Inner stage: keep the more urgent candidate; the left one wins on equal priority.
            for (genvar i = 0; i < W; i++) begin : g_i
                assign v[i] = (g_lvl[l-1].v[2*i].prio <= g_lvl[l-1].v[2*i+1].prio)
                            ? g_lvl[l-1].v[2*i] : g_lvl[l-1].v[2*i+1];
            end
        end
    end

    assign best_o = g_lvl[LOG].v[0];

    // R2 guard: a real winner always carries the index of an existing source.
    always_comb begin
        a_r2_winner_in_range: assert (best_o.prio[PRIO_W] || (int'(best_o.id) < N_SRC));
    end
endmodule

// File: rtl/grp_prio_gate.sv
// Module grp_prio_gate
// Purpose: turns the tree winner into the reported ID and the next IRQ and
//          FIQ levels, applying the enables, the mask, the running priority
//          and the FIQ steering.
// Assumes: best_i.prio = 0x100 means there is no candidate. Purely
//          combinational; the caller registers the outputs.
module grp_prio_gate
    import grp_prio_pkg::*;
(
    input  cand_t              best_i,
    input  logic               dist_en_g0_i,
    input  logic               dist_en_g1_i,
    input  logic               if_en_g0_i,
    input  logic               if_en_g1_i,
    input  logic               if_fiq_en_i,
    input  logic [PCMP_W-1:0]  prio_mask_i,
    input  logic [PCMP_W-1:0]  run_prio_i,
    output logic [ID_W-1:0]    id_o,
    output logic               irq_o,
    output logic               fiq_o
);
    logic all_off, valid, pass_mask, is_g0, grp_dist_on, fire, to_fiq;

    // Decision: whole-interface shutdown first, then the mask, then signalling.
    always_comb begin
        all_off     = (!dist_en_g0_i && !dist_en_g1_i) || (!if_en_g0_i && !if_en_g1_i);
        valid       = !best_i.prio[PRIO_W];
        pass_mask   = valid && (best_i.prio < prio_mask_i);
        is_g0       = !best_i.grp;
        grp_dist_on = is_g0 ? dist_en_g0_i : dist_en_g1_i;
        fire        = !all_off && pass_mask && grp_dist_on && (best_i.prio < run_prio_i);
        to_fiq      = is_g0 && if_fiq_en_i;
        id_o        = (!all_off && pass_mask) ? best_i.id : ID_NONE;
        fiq_o       = fire && to_fiq && if_en_g0_i;
        irq_o       = fire && !to_fiq && (is_g0 ? if_en_g0_i : if_en_g1_i);
    end
endmodule

// File: rtl/grp_prio_select.sv
// Module grp_prio_select (top)
// Purpose: selector for one processor interface. Forms the eligibility of
//          each source, runs the comparison tree and the gate, and registers
//          the ID, IRQ and FIQ outputs.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module grp_prio_select
    import grp_prio_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_en_i,
    input  logic [N_SRC-1:0]        src_pend_i,
    input  logic [N_SRC-1:0]        src_grp_i,
    input  logic [8*N_SRC-1:0]      src_prio_i,
    input  logic                    dist_en_g0_i,
    input  logic                    dist_en_g1_i,
    input  logic                    if_en_g0_i,
    input  logic                    if_en_g1_i,
    input  logic                    if_fiq_en_i,
    input  logic [8:0]              prio_mask_i,
    input  logic [8:0]              run_prio_i,
    output logic [9:0]              pend_id_o,
    output logic                    irq_o,
    output logic                    fiq_o
);
    logic [N_SRC-1:0] elig;
    cand_t            best;
    logic [ID_W-1:0]  id_nxt;
    logic             irq_nxt, fiq_nxt;

    // Eligibility: a source competes only when it is enabled and pending.
    always_comb elig = src_en_i & src_pend_i;

    grp_prio_tree #(.N_SRC(N_SRC)) u_tree (
        .elig_i (elig),
        .grp_i  (src_grp_i),
        .prio_i (src_prio_i),
        .best_o (best)
    );

    grp_prio_gate u_gate (
        .best_i       (best),
        .dist_en_g0_i (dist_en_g0_i),
        .dist_en_g1_i (dist_en_g1_i),
        .if_en_g0_i   (if_en_g0_i),
        .if_en_g1_i   (if_en_g1_i),
        .if_fiq_en_i  (if_fiq_en_i),
        .prio_mask_i  (prio_mask_i),
        .run_prio_i   (run_prio_i),
        .id_o         (id_nxt),
        .irq_o        (irq_nxt),
        .fiq_o        (fiq_nxt)
    );

    // Output registers: one clock of latency, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_id_o <= ID_NONE;
            irq_o     <= 1'b0;
            fiq_o     <= 1'b0;
        end else begin
            pend_id_o <= id_nxt;
            irq_o     <= irq_nxt;
            fiq_o     <= fiq_nxt;
        end
    end

    // R4: with both distributor group enables off, the next outputs are idle.
    a_r4_dist_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!dist_en_g0_i && !dist_en_g1_i) |=> (!irq_o && !fiq_o && pend_id_o == ID_NONE));

    // R6: with a running priority of 0, nothing can pre-empt it.
    a_r6_run_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio_i == 9'd0) |=> (!irq_o && !fiq_o));

    // R8: FIQ is never raised when steering is off.
    a_r8_fiq_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
        !if_fiq_en_i |=> !fiq_o);

    // R8: the two lines are never raised together.
    a_r8_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, fiq_o}));

    // R5: a raised line always comes with a reported ID.
    a_r5_line_has_id: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (pend_id_o != ID_NONE));
endmodule

// File: tb/grp_prio_select_test.sv
`timescale 1ns/1ps
module grp_prio_select_test;
    localparam int N = 64;
    localparam logic [9:0] NONE = 10'd1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   en, pend, grp;
    logic [8*N-1:0] prio;
    logic de0, de1, ie0, ie1, fe;
    logic [8:0] mask, run;
    logic [9:0] id;
    logic irq, fiq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    grp_prio_select #(.N_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .src_en_i(en), .src_pend_i(pend), .src_grp_i(grp), .src_prio_i(prio),
        .dist_en_g0_i(de0), .dist_en_g1_i(de1),
        .if_en_g0_i(ie0), .if_en_g1_i(ie1), .if_fiq_en_i(fe),
        .prio_mask_i(mask), .run_prio_i(run),
        .pend_id_o(id), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(string req, logic [9:0] e_id, logic e_irq, logic e_fiq);
        n_chk++;
        if (id !== e_id || irq !== e_irq || fiq !== e_fiq) begin
            n_bad++;
            $display("FAIL %s: got id=%0d irq=%0b fiq=%0b, expected id=%0d irq=%0b fiq=%0b",
                     req, id, irq, fiq, e_id, e_irq, e_fiq);
        end
    endtask

    task automatic clear_src();
        en = '0; pend = '0; grp = '0; prio = '0;
    endtask

    task automatic set_src(int i, bit g, logic [7:0] p);
        en[i] = 1'b1; pend[i] = 1'b1; grp[i] = g; prio[i*8 +: 8] = p;
    endtask

    task automatic cfg(bit d0, bit d1, bit i0, bit i1, bit f, logic [8:0] m, logic [8:0] r);
        de0 = d0; de1 = d1; ie0 = i0; ie1 = i1; fe = f; mask = m; run = r;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R1: outputs idle during reset
        clear_src(); set_src(3, 1'b1, 8'h01);
        cfg(1, 1, 1, 1, 0, 9'h100, 9'h100);
        repeat (3) @(negedge clk);
        check("R1 in reset", NONE, 0, 0);
        rst_n = 1'b1;
        #2 check("R1 first cycle after reset", NONE, 0, 0);
        settle();
    endtask

    task automatic t_select();
        // R2: disabled and non-pending sources are ignored
        clear_src(); cfg(1, 1, 1, 1, 0, 9'h100, 9'h100);
        set_src(5, 1, 8'h40); set_src(9, 1, 8'h20);
        set_src(12, 1, 8'h10); en[12] = 1'b0;
        set_src(20, 1, 8'h05); pend[20] = 1'b0;
        settle(); check("R2 enabled+pending minimum", 10'd9, 1, 0);
        set_src(63, 1, 8'h00);
        settle(); check("R2 top index wins", 10'd63, 1, 0);
    endtask

    task automatic t_tie();
        // R3: equal priority resolves to the lower index
        clear_src(); cfg(1, 1, 1, 1, 0, 9'h100, 9'h100);
        set_src(30, 1, 8'h33); set_src(7, 1, 8'h33);
        settle(); check("R3 tie 7 vs 30", 10'd7, 1, 0);
        clear_src(); set_src(63, 1, 8'hFF); set_src(0, 1, 8'hFF);
        settle(); check("R3 tie at 0xFF, 0 vs 63", 10'd0, 1, 0);
    endtask

    task automatic t_off();
        // R4: global shutdown from either side
        clear_src(); set_src(4, 0, 8'h10);
        cfg(0, 0, 1, 1, 1, 9'h100, 9'h100);
        settle(); check("R4 distributor both off", NONE, 0, 0);
        cfg(1, 1, 0, 0, 1, 9'h100, 9'h100);
        settle(); check("R4 interface both off", NONE, 0, 0);
    endtask

    task automatic t_mask();
        // R5: strict compare against the mask
        clear_src(); set_src(11, 1, 8'h50);
        cfg(1, 1, 1, 1, 0, 9'h050, 9'h100);
        settle(); check("R5 mask equal blocks", NONE, 0, 0);
        mask = 9'h051;
        settle(); check("R5 mask above passes", 10'd11, 1, 0);
    endtask

    task automatic t_run();
        // R6: strict compare against the running priority
        clear_src(); set_src(17, 1, 8'h50);
        cfg(1, 1, 1, 1, 0, 9'h100, 9'h050);
        settle(); check("R6 run equal: id only", 10'd17, 0, 0);
        run = 9'h051;
        settle(); check("R6 run above: signalled", 10'd17, 1, 0);
    endtask

    task automatic t_distgrp();
        // R7: a group-1 winner disabled at the distributor hides a group-0 source
        clear_src(); set_src(2, 1, 8'h10); set_src(40, 0, 8'h60);
        cfg(1, 0, 1, 1, 0, 9'h100, 9'h100);
        settle(); check("R7 winner group off at distributor", 10'd2, 0, 0);
        cfg(1, 1, 1, 1, 0, 9'h100, 9'h100);
        settle(); check("R7 group re-enabled", 10'd2, 1, 0);
    endtask

    task automatic t_lines();
        clear_src(); set_src(8, 0, 8'h20);
        cfg(1, 1, 1, 1, 1, 9'h100, 9'h100);
        settle(); check("R8 group0 steered to FIQ", 10'd8, 0, 1);
        cfg(1, 1, 0, 1, 1, 9'h100, 9'h100);
        settle(); check("R9 steered but g0 interface off", 10'd8, 0, 0);
        cfg(1, 1, 1, 0, 0, 9'h100, 9'h100);
        settle(); check("R10 group0 unsteered IRQ", 10'd8, 1, 0);
        clear_src(); set_src(8, 1, 8'h20);
        cfg(1, 1, 1, 0, 1, 9'h100, 9'h100);
        settle(); check("R10 group1 with g1 interface off", 10'd8, 0, 0);
        cfg(1, 1, 0, 1, 1, 9'h100, 9'h100);
        settle(); check("R10 group1 IRQ despite steering", 10'd8, 1, 0);
    endtask

    task automatic t_latency();
        // R11: one register stage
        clear_src(); set_src(1, 1, 8'h30);
        cfg(1, 1, 1, 1, 0, 9'h100, 9'h100);
        settle(); check("R11 setup", 10'd1, 1, 0);
        set_src(50, 1, 8'h08);
        #2 check("R11 holds before edge", 10'd1, 1, 0);
        settle(); check("R11 updates after edge", 10'd50, 1, 0);
    endtask

    initial begin
        clear_src(); cfg(0, 0, 0, 0, 0, 9'h100, 9'h100);
        t_reset();
        t_select();
        t_tie();
        t_off();
        t_mask();
        t_run();
        t_distgrp();
        t_lines();
        t_latency();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule